// File: doc/BRIEF.md
# Self-Test Wrapper for a Pipelined Multiplier

This block sits between an arithmetic unit, normally a multiplier with a fixed pipeline depth, and the logic that feeds it. In normal operation the operands from the surrounding logic go straight through to the unit. When the test input is raised, two pseudo-random generators take over the operand path instead. Each generator is a maximal-length linear feedback shift register with its own seed.

Every response the unit returns during a test run is compared with an expected value held in a table inside the wrapper. The table is filled when the design is elaborated, from the same seeds and polynomial. A single pass flag reports the result. It falls on the first wrong response and stays low until the next run. A done output marks the point where the last comparison has reached the flag.

Top module: `selftest_mul_wrap`

## Requirements
- R1: Each operand generator is an OP_W-bit Fibonacci register. It steps as `next = {s[OP_W-2:0], ^(s & TAP)}`, where TAP is 0xB8 for OP_W = 8 (feedback from bits 7, 5, 4 and 3). Its state is never zero.
- R2: With `test_en` = 0, `cut_a`/`cut_b` equal `pi_a`/`pi_b` in the same cycle. With `test_en` = 1, they carry the generator states and `pi_a`/`pi_b` have no effect on them.
- R3: In the first cycle with `test_en` high, the applied pattern is (SEED_A, SEED_B), which defaults to (0x5A, 0xC3). In cycle k after that first cycle, the pattern is the k-th successor of both seeds. Every run, including one that follows an aborted run, starts again from the seeds.
- R4: Table entry k holds the full 2·OP_W-bit product of pattern k's operands. The `cut_y` value seen CUT_LAT cycles after pattern k was applied is compared with entry k.
- R5: If every compared response matches, `pass_flag` stays 1 for the whole run and is still 1 while `done` is high.
- R6: If the response for pattern j mismatches, `pass_flag` is 0 from cycle j+CUT_LAT+1 of the run. It stays 0 for the rest of that run, including after `done`.
- R7: `done` is 0 in cycles 0 to NUM_PAT+CUT_LAT−1 of a run and 1 from cycle NUM_PAT+CUT_LAT for as long as `test_en` stays high.
- R8: After NUM_PAT patterns, both generators freeze at the NUM_PAT-th successor of their seeds for as long as `test_en` stays high.
- R9: When `test_en` is 0, `done` is 0 in the same cycle and `pass_flag` is 1 from the next cycle on. A wrong `cut_y` in normal mode leaves `pass_flag` at 1.
- R10: While `rst` is high, `pass_flag` is 1, `done` is 0 and both generators hold their seeds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | 1 = self-test run, 0 = normal operand path |
| pi_a | input | OP_W | Normal-mode operand A |
| pi_b | input | OP_W | Normal-mode operand B |
| cut_y | input | 2·OP_W | Result returned by the unit under test |
| cut_a | output | OP_W | Operand A to the unit under test |
| cut_b | output | OP_W | Operand B to the unit under test |
| pass_flag | output | 1 | 1 = no mismatch seen in this run |
| done | output | 1 | All patterns applied and all responses compared |

## Verification
A generator stepping on the wrong cycle, or restarting from the wrong point, shows up on `cut_a`/`cut_b` in the very cycle where it goes wrong. The bench checks the operands against its own model in every cycle of every run. A misaligned table address or compare delay leaves a fault-free unit reported as failing, or lets an injected fault at a chosen pattern go unnoticed. Either one shows on `pass_flag` at cycle j+CUT_LAT+1 of the run. Faults are placed at the first pattern, the last pattern and random positions, so off-by-one errors at both ends of the schedule are caught, as is a flag that fails to stay low.

// File: rtl/bist_pkg.sv
package bist_pkg;

    // Control strobes from the sequencer to the datapath
    typedef struct packed {
        logic load;    // hold generators at their seeds
        logic step;    // advance generators one pattern
        logic cmp_en;  // a response is due on cut_y this cycle
        logic done;    // schedule finished
    } bist_ctl_t;

    // Fibonacci feedback masks of maximal-length polynomials, bit w-1 is the top stage
    function automatic logic [31:0] tap_mask(input int w);
        case (w)
            4:       return 32'h0000_000C;
            5:       return 32'h0000_0014;
            6:       return 32'h0000_0030;
            7:       return 32'h0000_0060;
            8:       return 32'h0000_00B8;
            9:       return 32'h0000_0110;
            10:      return 32'h0000_0240;
            12:      return 32'h0000_0829;
            16:      return 32'h0000_D008;
            default: return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [31:0] lfsr_next(input logic [31:0] s, input int w);
        logic [31:0] keep;
        logic        fb;
        keep = (32'h1 << w) - 32'h1;
        fb   = ^(s & tap_mask(w));
        return ((s << 1) | {31'b0, fb}) & keep;
    endfunction

    function automatic logic [31:0] lfsr_after(input logic [31:0] seed, input int w, input int n);
        logic [31:0] s;
        s = seed;
        for (int i = 0; i < n; i++) s = lfsr_next(s, w);
        return s;
    endfunction

    // Expected unit response for pattern k
    function automatic logic [63:0] expected_product(input logic [31:0] seed_a,
                                                     input logic [31:0] seed_b,
                                                     input int w, input int k);
        logic [63:0] a;
        logic [63:0] b;
        a = {32'b0, lfsr_after(seed_a, w, k)};
        b = {32'b0, lfsr_after(seed_b, w, k)};
        return a * b;
    endfunction

endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
    parameter int             W    = 8,
    parameter logic [W-1:0]   SEED = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    output logic [W-1:0] state
);
    localparam logic [31:0] TAPS = bist_pkg::tap_mask(W);

    logic [W-1:0] nxt;

    always_comb nxt = {state[W-2:0], ^(state & TAPS[W-1:0])};

    always_ff @(posedge clk) begin
        if (rst || load)
            state <= SEED;
        else if (step)
            state <= nxt;
    end

    // A maximal-length register seeded non-zero never reaches the lock-up state
    assert_lfsr_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl #(
    parameter  int NUM_PAT = 16,
    parameter  int LAT     = 2,
    localparam int AW      = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 test_en,
    output bist_pkg::bist_ctl_t  ctl,
    output logic [AW-1:0]        cmp_addr
);
    localparam int LIMIT = NUM_PAT + LAT;
    localparam int TW    = $clog2(LIMIT + 1);

    // One counter schedules stepping, table address and completion
    logic [TW-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst || !test_en)
            tick <= '0;
        else if (int'(tick) != LIMIT)
            tick <= tick + 1'b1;
    end

    always_comb begin
        ctl.load   = !test_en;
        ctl.step   = test_en && (int'(tick) < NUM_PAT);
        ctl.cmp_en = test_en && (int'(tick) >= LAT) && (int'(tick) < LIMIT);
        ctl.done   = test_en && (int'(tick) == LIMIT);
        cmp_addr   = AW'(int'(tick) - LAT);
    end

    // R7: completion persists while the run is held
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl.done && test_en) |=> (ctl.done || !test_en));

    // R8: no stepping once completion is reached
    assert_no_step_after_done_R8: assert property (@(posedge clk) disable iff (rst)
        ctl.done |-> !ctl.step);

endmodule

// File: rtl/bist_rom_cmp.sv
module bist_rom_cmp #(
    parameter  int           W       = 8,
    parameter  int           NUM_PAT = 16,
    parameter  logic [W-1:0] SEED_A  = '1,
    parameter  logic [W-1:0] SEED_B  = '1,
    localparam int           PW      = 2 * W,
    localparam int           AW      = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          test_en,
    input  logic          cmp_en,
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] cut_y,
    output logic          pass_flag
);
    logic [PW-1:0] rom [NUM_PAT];
    logic [PW-1:0] exp_y;
    logic          mismatch;

    for (genvar i = 0; i < NUM_PAT; i++) begin : g_rom
        localparam logic [63:0] ENTRY =
            bist_pkg::expected_product(32'(SEED_A), 32'(SEED_B), W, i);
        assign rom[i] = ENTRY[PW-1:0];
    end

    // Table is only addressed when a response is due
    always_comb begin
        exp_y    = cmp_en ? rom[addr] : '0;
        mismatch = cmp_en && (cut_y != exp_y);
    end

    always_ff @(posedge clk) begin
        if (rst || !test_en)
            pass_flag <= 1'b1;
        else if (mismatch)
            pass_flag <= 1'b0;
    end

    // R6: a failure is kept until the run ends
    assert_fail_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (test_en && !pass_flag) |=> !pass_flag);

    // R9: normal mode always reports pass
    assert_normal_pass_R9: assert property (@(posedge clk) disable iff (rst)
        !test_en |=> pass_flag);

endmodule

// File: rtl/selftest_mul_wrap.sv
module selftest_mul_wrap #(
    parameter  int              OP_W    = 8,
    parameter  int              NUM_PAT = 16,
    parameter  int              CUT_LAT = 2,
    parameter  logic [OP_W-1:0] SEED_A  = OP_W'(32'h5A),
    parameter  logic [OP_W-1:0] SEED_B  = OP_W'(32'hC3),
    localparam int              PW      = 2 * OP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            test_en,
    input  logic [OP_W-1:0] pi_a,
    input  logic [OP_W-1:0] pi_b,
    input  logic [PW-1:0]   cut_y,
    output logic [OP_W-1:0] cut_a,
    output logic [OP_W-1:0] cut_b,
    output logic            pass_flag,
    output logic            done
);
    localparam int AW = (NUM_PAT > 1) ? $clog2(NUM_PAT) : 1;

    bist_pkg::bist_ctl_t ctl;
    logic [AW-1:0]       cmp_addr;
    logic [OP_W-1:0]     gen_a;
    logic [OP_W-1:0]     gen_b;

    bist_ctrl #(.NUM_PAT(NUM_PAT), .LAT(CUT_LAT)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .test_en  (test_en),
        .ctl      (ctl),
        .cmp_addr (cmp_addr)
    );

    bist_lfsr #(.W(OP_W), .SEED(SEED_A)) u_gen_a (
        .clk   (clk),
        .rst   (rst),
        .load  (ctl.load),
        .step  (ctl.step),
        .state (gen_a)
    );

    bist_lfsr #(.W(OP_W), .SEED(SEED_B)) u_gen_b (
        .clk   (clk),
        .rst   (rst),
        .load  (ctl.load),
        .step  (ctl.step),
        .state (gen_b)
    );

    bist_rom_cmp #(.W(OP_W), .NUM_PAT(NUM_PAT), .SEED_A(SEED_A), .SEED_B(SEED_B)) u_check (
        .clk       (clk),
        .rst       (rst),
        .test_en   (test_en),
        .cmp_en    (ctl.cmp_en),
        .addr      (cmp_addr),
        .cut_y     (cut_y),
        .pass_flag (pass_flag)
    );

    // Shared operand path: test patterns or primary inputs
    always_comb begin
        cut_a = test_en ? gen_a : pi_a;
        cut_b = test_en ? gen_b : pi_b;
        done  = ctl.done;
    end

    // R3: a run always opens with the seed pair
    assert_seed_on_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(test_en) |-> (cut_a == SEED_A && cut_b == SEED_B));

    // R8: operands frozen once the schedule completes
    assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> ($stable(cut_a) && $stable(cut_b)));

endmodule

// File: tb/tb_selftest_mul_wrap.sv
module tb_selftest_mul_wrap;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 8;
    localparam int NP  = 16;
    localparam int LAT = 2;
    localparam logic [W-1:0] SA = 8'h5A;
    localparam logic [W-1:0] SB = 8'hC3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           test_en = 1'b0;
    logic [W-1:0]   pi_a = '0;
    logic [W-1:0]   pi_b = '0;
    logic [2*W-1:0] cut_y;
    logic [W-1:0]   cut_a;
    logic [W-1:0]   cut_b;
    logic           pass_flag;
    logic           done;

    int checks = 0;
    int errors = 0;

    // fault injection into the stand-in unit
    logic         fault_armed  = 1'b0;
    logic         fault_always = 1'b0;
    logic [W-1:0] fault_a = '0;
    logic [W-1:0] fault_b = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    selftest_mul_wrap #(.OP_W(W), .NUM_PAT(NP), .CUT_LAT(LAT), .SEED_A(SA), .SEED_B(SB)) dut (
        .clk(clk), .rst(rst), .test_en(test_en), .pi_a(pi_a), .pi_b(pi_b),
        .cut_y(cut_y), .cut_a(cut_a), .cut_b(cut_b), .pass_flag(pass_flag), .done(done)
    );

    // Stand-in unit: multiplier with two pipeline registers
    logic [2*W-1:0] prod_now;
    logic [2*W-1:0] pipe0;
    logic [2*W-1:0] pipe1;
    always_comb begin
        prod_now = {8'b0, cut_a} * {8'b0, cut_b};
        if (fault_always || (fault_armed && test_en && cut_a == fault_a && cut_b == fault_b))
            prod_now = prod_now ^ 16'h0001;
    end
    always_ff @(posedge clk) begin
        pipe0 <= prod_now;
        pipe1 <= pipe0;
    end
    assign cut_y = pipe1;

    function automatic logic [W-1:0] m_next(input logic [W-1:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [W-1:0] m_pat(input logic [W-1:0] seed, input int k);
        logic [W-1:0] s;
        s = seed;
        for (int i = 0; i < k; i++) s = m_next(s);
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic next_cycle();
        @(posedge clk);
        #1;
    endtask

    // One full run; fidx < 0 means fault-free unit
    task automatic run_test(input int fidx);
        if (fidx >= 0) begin
            fault_a = m_pat(SA, fidx);
            fault_b = m_pat(SB, fidx);
            fault_armed = 1'b1;
        end
        next_cycle();
        test_en = 1'b1;
        for (int c = 0; c < NP + LAT + 4; c++) begin
            int  p;
            logic ef;
            pi_a = W'($urandom);
            pi_b = W'($urandom);
            @(negedge clk);
            p = (c < NP) ? c : NP;
            if (c == 0) begin
                chk("R3 seed A", 32'(cut_a), 32'(SA));
                chk("R3 seed B", 32'(cut_b), 32'(SB));
            end else if (c >= NP) begin
                chk("R8 frozen A", 32'(cut_a), 32'(m_pat(SA, NP)));
                chk("R8 frozen B", 32'(cut_b), 32'(m_pat(SB, NP)));
            end else begin
                chk("R1 R2 pattern A", 32'(cut_a), 32'(m_pat(SA, p)));
                chk("R1 R2 pattern B", 32'(cut_b), 32'(m_pat(SB, p)));
            end
            chk("R7 done", 32'(done), 32'(c >= NP + LAT));
            ef = (fidx < 0) || (c <= fidx + LAT);
            chk(fidx < 0 ? "R4 R5 clean flag" : "R6 sticky fail flag", 32'(pass_flag), 32'(ef));
            next_cycle();
        end
        test_en = 1'b0;
        fault_armed = 1'b0;
        @(negedge clk);
        chk("R9 done drops", 32'(done), 32'd0);
        chk("R2 passthrough", 32'(cut_a), 32'(pi_a));
        next_cycle();
        @(negedge clk);
        chk("R9 flag back to pass", 32'(pass_flag), 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R10: state under reset, even with test requested
        test_en = 1'b1;
        repeat (3) next_cycle();
        @(negedge clk);
        chk("R10 flag in reset", 32'(pass_flag), 32'd1);
        chk("R10 done in reset", 32'(done), 32'd0);
        chk("R10 seed in reset", 32'(cut_a), 32'(SA));
        next_cycle();
        test_en = 1'b0;
        next_cycle();
        rst = 1'b0;
        next_cycle();

        // R2 R9: normal mode with a broken unit
        fault_always = 1'b1;
        for (int i = 0; i < 8; i++) begin
            pi_a = W'($urandom);
            pi_b = W'($urandom);
            @(negedge clk);
            chk("R2 normal A", 32'(cut_a), 32'(pi_a));
            chk("R2 normal B", 32'(cut_b), 32'(pi_b));
            chk("R9 flag in normal", 32'(pass_flag), 32'd1);
            chk("R9 done in normal", 32'(done), 32'd0);
            next_cycle();
        end
        fault_always = 1'b0;
        repeat (3) next_cycle();

        // directed runs
        run_test(-1);
        run_test(0);
        run_test(NP - 1);

        // aborted run followed by a restart from the seeds
        test_en = 1'b1;
        repeat (6) next_cycle();
        test_en = 1'b0;
        next_cycle();
        run_test(-1);

        // random runs
        for (int r = 0; r < 8; r++) begin
            int f;
            f = (($urandom % 3) == 0) ? -1 : int'($urandom % NP);
            run_test(f);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule